// File: doc/BRIEF.md
# Host Processor Mailbox

This block lets an external host processor and an on-chip controller trade 16-bit words through a small set of mailbox registers. The host reaches them over the same 16-bit bus that DMA transfers use. It drives active-low read and write strobes and one select pin. With select high, a host write loads the inbound word and a host read returns the outbound word. With select low, a host read returns the status flags and a host write has no effect. Host strobes are synchronized into the controller clock. Each access takes effect once, in the cycle after the release of its strobe is seen. Any access that completes while DMA owns the bus is dropped.

The controller side has a simple register port: read the inbound word, write or read back the outbound word, read the status, clear interrupts, and set one mailbox enable bit. There are two interrupt lines. One is raised when the host deposits an inbound word. The other is raised when the host has finished taking the outbound word. Both are held until the controller clears them, and both are masked by the enable bit.

Top module: `hostmbx_top`

## Requirements
- R1: After reset the inbound and outbound words, the full flags, both pending interrupts, the enable bit, both interrupt outputs and the host bus enable are all zero.
- R2: A host write with select high loads the inbound word and sets inbound-full. A controller read at address 0 returns that word and clears inbound-full.
- R3: A controller write at address 1 loads the outbound word and sets outbound-full. While the host read strobe is low with select high, the host bus carries the outbound word. When that read is released, outbound-full clears.
- R4: With select low, a host read returns the status word: bit 0 inbound-full, bit 1 outbound-full, bit 2 inbound pending, bit 3 outbound pending, all other bits zero. A host write with select low changes nothing. A controller read at address 2 returns the same word.
- R5: While dma_busy is high, the host bus enable stays low. A host access whose strobe is released while dma_busy is high changes no register, flag or interrupt.
- R6: A completed inbound host write sets the inbound pending bit and drives irq_in high when the enable bit (address 3, bit 0) is one.
- R7: A completed outbound host read sets the outbound pending bit and drives irq_out high when the enable bit is one.
- R8: While the enable bit is zero, host accesses set no pending bit and both interrupt outputs stay low. The full flags still follow R2 and R3.
- R9: A controller write at address 2 clears inbound pending where bit 2 is one and outbound pending where bit 3 is one. It leaves the data words and full flags unchanged.
- R10: When a set and a clear of the same flag or pending bit fall in the same cycle, the set wins.
- R11: A host strobe held low has no effect until it is released, and each release acts exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_data_in | input | 16 | Host data bus, write direction |
| hb_data_out | output | 16 | Host data bus, read direction |
| hb_data_oe | output | 1 | Drive enable for the host bus |
| hb_sel | input | 1 | 1 selects data words, 0 selects status |
| hb_wr_n | input | 1 | Host write strobe, active low |
| hb_rd_n | input | 1 | Host read strobe, active low |
| dma_busy | input | 1 | DMA owns the shared bus |
| cpu_addr | input | 2 | Controller register address |
| cpu_wr | input | 1 | Controller write strobe |
| cpu_rd | input | 1 | Controller read strobe |
| cpu_wdata | input | 16 | Controller write data |
| cpu_rdata | output | 16 | Controller read data |
| irq_in | output | 1 | Inbound word arrived |
| irq_out | output | 1 | Outbound word consumed |

## Verification
Two things can land on the same clock edge. A released host write can set inbound-full while the controller reads address 0 and clears it. The same released write can raise inbound pending while the controller writes a clear to that pending bit. The bench finds the edge where the release takes effect by counting the synchronizer stages, and it drives the controller access in that exact cycle. It then passes only if the flag and the pending bit are still set, the controller got the older word, and the newer word is waiting at address 0.

// File: rtl/mbx_pkg.sv
// Shared constants for the host mailbox: status bit positions and
// controller register addresses.
package mbx_pkg;
    localparam int ST_IN_FULL  = 0;
    localparam int ST_OUT_FULL = 1;
    localparam int ST_IN_PEND  = 2;
    localparam int ST_OUT_PEND = 3;
    localparam int ST_BITS     = 4;

    typedef enum logic [1:0] {
        A_INBOX  = 2'd0,
        A_OUTBOX = 2'd1,
        A_STATUS = 2'd2,
        A_ENABLE = 2'd3
    } cpu_addr_e;
endpackage

// File: rtl/mbx_strobe_sync.sv
// Brings an asynchronous active-low strobe into the clock domain and
// gives a one-cycle pulse when its release (low to high) is seen.
// Assumes STAGES >= 2 and that the strobe is idle high at reset.
module mbx_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic release_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // shift the strobe through the synchronizer and keep the last value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], strobe_n};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign release_pulse = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/mbx_irq.sv
// Holds the pending bits for each interrupt source. A bit is set by an
// event while the enable is one, and it is cleared by a write-one
// request. A set wins over a clear in the same cycle. Outputs are
// masked by the enable.
module mbx_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] set_evt,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] pend,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        // per-source pending bit, set over clear
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[i] <= 1'b0;
            else if (set_evt[i] && en)
                pend[i] <= 1'b1;
            else if (clr_req[i])
                pend[i] <= 1'b0;
        end
        assign irq[i] = pend[i] & en;
    end
endmodule

// File: rtl/mbx_regs.sv
// Data words, full flags and enable bit of the mailbox. Host events
// arrive as single-cycle pulses. Controller accesses are single-cycle
// strobes with an address. Sets take priority over clears.
module mbx_regs
    import mbx_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr_evt,
    input  logic          host_rd_evt,
    input  logic [DW-1:0] host_wdata,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [1:0]    cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] inbox,
    output logic [DW-1:0] outbox,
    output logic          in_full,
    output logic          out_full,
    output logic          en
);
    logic cpu_takes_in, cpu_fills_out, cpu_sets_en;

    assign cpu_takes_in  = cpu_rd && (cpu_addr == A_INBOX);
    assign cpu_fills_out = cpu_wr && (cpu_addr == A_OUTBOX);
    assign cpu_sets_en   = cpu_wr && (cpu_addr == A_ENABLE);

    // inbound word and its full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inbox   <= '0;
            in_full <= 1'b0;
        end else begin
            if (host_wr_evt) inbox <= host_wdata;
            if (host_wr_evt)       in_full <= 1'b1;
            else if (cpu_takes_in) in_full <= 1'b0;
        end
    end

    // outbound word and its full flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outbox   <= '0;
            out_full <= 1'b0;
        end else begin
            if (cpu_fills_out) outbox <= cpu_wdata;
            if (cpu_fills_out)    out_full <= 1'b1;
            else if (host_rd_evt) out_full <= 1'b0;
        end
    end

    // mailbox interrupt enable bit
    always_ff @(posedge clk) begin
        if (!rst_n)          en <= 1'b0;
        else if (cpu_sets_en) en <= cpu_wdata[0];
    end
endmodule

// File: rtl/hostmbx_top.sv
// Host mailbox top. It joins the strobe synchronizers, the register
// set and the interrupt logic, and it decodes both access ports. The
// host select and write data must be stable from strobe assertion
// until the release is taken, a few clocks later.
module hostmbx_top
    import mbx_pkg::*;
#(
    parameter int DW        = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] hb_data_in,
    output logic [DW-1:0] hb_data_out,
    output logic          hb_data_oe,
    input  logic          hb_sel,
    input  logic          hb_wr_n,
    input  logic          hb_rd_n,
    input  logic          dma_busy,
    input  logic [1:0]    cpu_addr,
    input  logic          cpu_wr,
    input  logic          cpu_rd,
    input  logic [DW-1:0] cpu_wdata,
    output logic [DW-1:0] cpu_rdata,
    output logic          irq_in,
    output logic          irq_out
);
    localparam int NSRC = 2;

    logic          wr_rel, rd_rel;
    logic          host_wr_evt, host_rd_evt;
    logic [DW-1:0] inbox, outbox, status;
    logic          in_full, out_full, mbx_en;
    logic [NSRC-1:0] irq_set, irq_clr, pend, irq_vec;

    mbx_strobe_sync #(.STAGES(SYNC_STGS)) u_wr_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(hb_wr_n), .release_pulse(wr_rel));
    mbx_strobe_sync #(.STAGES(SYNC_STGS)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .strobe_n(hb_rd_n), .release_pulse(rd_rel));

    // host events count only for data select and only with DMA idle
    assign host_wr_evt = wr_rel && hb_sel && !dma_busy;
    assign host_rd_evt = rd_rel && hb_sel && !dma_busy;

    mbx_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_wr_evt(host_wr_evt), .host_rd_evt(host_rd_evt),
        .host_wdata(hb_data_in),
        .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata),
        .inbox(inbox), .outbox(outbox),
        .in_full(in_full), .out_full(out_full), .en(mbx_en));

    assign irq_set = {host_rd_evt, host_wr_evt};
    assign irq_clr = (cpu_wr && (cpu_addr == A_STATUS)) ?
                     cpu_wdata[ST_OUT_PEND:ST_IN_PEND] : '0;

    mbx_irq #(.N(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .en(mbx_en),
        .set_evt(irq_set), .clr_req(irq_clr),
        .pend(pend), .irq(irq_vec));

    assign irq_in  = irq_vec[0];
    assign irq_out = irq_vec[1];

    // assemble the status word
    always_comb begin
        status              = '0;
        status[ST_IN_FULL]  = in_full;
        status[ST_OUT_FULL] = out_full;
        status[ST_IN_PEND]  = pend[0];
        status[ST_OUT_PEND] = pend[1];
    end

    // host read path: drive only while reading and DMA is idle
    assign hb_data_oe  = !hb_rd_n && !dma_busy;
    assign hb_data_out = hb_sel ? outbox : status;

    // controller read mux
    always_comb begin
        case (cpu_addr)
            A_INBOX:  cpu_rdata = inbox;
            A_OUTBOX: cpu_rdata = outbox;
            A_STATUS: cpu_rdata = status;
            default:  cpu_rdata = {{(DW-1){1'b0}}, mbx_en};
        endcase
    end
endmodule

// File: rtl/mbx_chk.sv
// Property checker for the host mailbox. It is attached to every
// hostmbx_top instance by the bind below and only observes.
module mbx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dma_busy,
    input logic       hb_data_oe,
    input logic       host_wr_evt,
    input logic       host_rd_evt,
    input logic       in_full,
    input logic       out_full,
    input logic       mbx_en,
    input logic [1:0] pend,
    input logic [1:0] irq_clr,
    input logic       irq_in
);
    // R5
    dma_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_busy |-> !hb_data_oe);

    // R2
    in_full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> $past(host_wr_evt));

    // R3
    out_drain_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_full) |-> $past(host_rd_evt));

    // R8
    masked_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mbx_en && !pend[0]) |=> !pend[0]);

    // R8
    masked_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mbx_en && !pend[1]) |=> !pend[1]);

    // R9
    w1c_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr[0] && !host_wr_evt) |=> !irq_in);
endmodule

bind hostmbx_top mbx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dma_busy(dma_busy), .hb_data_oe(hb_data_oe),
    .host_wr_evt(host_wr_evt), .host_rd_evt(host_rd_evt),
    .in_full(in_full), .out_full(out_full), .mbx_en(mbx_en),
    .pend(pend), .irq_clr(irq_clr), .irq_in(irq_in));

// File: tb/sim_hostmbx_top.sv
`timescale 1ns/1ps
module sim_hostmbx_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] hb_data_in = '0;
    logic [15:0] hb_data_out;
    logic        hb_data_oe;
    logic        hb_sel = 1'b1;
    logic        hb_wr_n = 1'b1;
    logic        hb_rd_n = 1'b1;
    logic        dma_busy = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        irq_in, irq_out;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    hostmbx_top u0 (
        .clk(clk), .rst_n(rst_n), .hb_data_in(hb_data_in),
        .hb_data_out(hb_data_out), .hb_data_oe(hb_data_oe),
        .hb_sel(hb_sel), .hb_wr_n(hb_wr_n), .hb_rd_n(hb_rd_n),
        .dma_busy(dma_busy), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
        .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .irq_in(irq_in), .irq_out(irq_out));

    localparam logic [2:0] K_HW = 3'd0, K_HWS = 3'd1, K_HR = 3'd2, K_HRS = 3'd3,
                           K_CR0 = 3'd4, K_CW1 = 3'd5, K_CW2 = 3'd6, K_CW3 = 3'd7;

    typedef struct packed {
        logic [2:0]  kind;
        logic [15:0] arg;
        logic [15:0] expv;
        logic [3:0]  exps;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{K_CW3, 16'h0001, 16'h0000, 4'h0},   // enable on
        '{K_HW,  16'hA5A5, 16'h0000, 4'h5},   // R6 inbound irq
        '{K_HRS, 16'h0000, 16'h0005, 4'h5},   // status via host
        '{K_CR0, 16'h0000, 16'hA5A5, 4'h4},   // take inbound word
        '{K_CW2, 16'h0004, 16'h0000, 4'h0},   // clear inbound irq
        '{K_CW1, 16'h1234, 16'h0000, 4'h2},   // fill outbound
        '{K_HR,  16'h0000, 16'h1234, 4'h8},   // R7 outbound irq
        '{K_CW2, 16'h0008, 16'h0000, 4'h0},   // clear outbound irq
        '{K_HWS, 16'hFFFF, 16'h0000, 4'h0},   // status write ignored
        '{K_CW3, 16'h0000, 16'h0000, 4'h0},   // enable off
        '{K_HW,  16'h0F0F, 16'h0000, 4'h1},   // masked inbound
        '{K_CR0, 16'h0000, 16'h0F0F, 4'h0},
        '{K_CW1, 16'hBEEF, 16'h0000, 4'h2},
        '{K_HR,  16'h0000, 16'hBEEF, 4'h0},   // masked outbound
        '{K_CW3, 16'h0001, 16'h0000, 4'h0}
    };

    function automatic string req_of(logic [2:0] k);
        case (k)
            K_HW, K_CR0:  return "R2";
            K_HR, K_CW1:  return "R3";
            K_HWS, K_HRS: return "R4";
            K_CW2:        return "R9";
            default:      return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_read(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic cpu_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic host_write(input logic sel, input logic [15:0] d);
        @(negedge clk);
        hb_sel = sel; hb_data_in = d; hb_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        hb_wr_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic host_read(input logic sel, output logic [15:0] v, output logic oe);
        @(negedge clk);
        hb_sel = sel; hb_rd_n = 1'b0;
        repeat (2) @(negedge clk);
        v = hb_data_out; oe = hb_data_oe;
        hb_rd_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // host write whose release lands together with a controller access
    task automatic host_write_collide(input logic [15:0] d, input logic do_clr, output logic [15:0] v);
        @(negedge clk);
        hb_sel = 1'b1; hb_data_in = d; hb_wr_n = 1'b0;
        repeat (2) @(negedge clk);
        hb_wr_n = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        if (do_clr) begin
            cpu_addr = 2'd2; cpu_wdata = 16'h0004; cpu_wr = 1'b1;
        end else begin
            cpu_addr = 2'd0; cpu_rd = 1'b1;
        end
        #1 v = cpu_rdata;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic        oe;

        // R1 reset values at the ports
        repeat (3) @(negedge clk);
        check("R1 irq", {30'b0, irq_out, irq_in}, 32'h0);
        check("R1 oe", {31'b0, hb_data_oe}, 32'h0);
        rst_n = 1'b1;
        cpu_read(2'd2, v); check("R1 status", {16'b0, v}, 32'h0);
        cpu_read(2'd1, v); check("R1 outbox", {16'b0, v}, 32'h0);
        cpu_read(2'd0, v); check("R1 inbox", {16'b0, v}, 32'h0);
        cpu_read(2'd3, v); check("R1 enable", {16'b0, v}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            v = '0;
            case (VECS[i].kind)
                K_HW:  host_write(1'b1, VECS[i].arg);
                K_HWS: host_write(1'b0, VECS[i].arg);
                K_HR:  host_read(1'b1, v, oe);
                K_HRS: host_read(1'b0, v, oe);
                K_CR0: cpu_read(2'd0, v);
                K_CW1: cpu_write(2'd1, VECS[i].arg);
                K_CW2: cpu_write(2'd2, VECS[i].arg);
                default: cpu_write(2'd3, VECS[i].arg);
            endcase
            check(req_of(VECS[i].kind), {16'b0, v}, {16'b0, VECS[i].expv});
            check(req_of(VECS[i].kind), {30'b0, irq_out, irq_in}, {30'b0, VECS[i].exps[3:2]});
            cpu_read(2'd2, v);
            check(req_of(VECS[i].kind), {16'b0, v}, {28'b0, VECS[i].exps});
        end

        // R5 DMA lockout
        cpu_write(2'd1, 16'h5151);
        dma_busy = 1'b1;
        host_write(1'b1, 16'h7777);
        host_read(1'b1, v, oe);
        check("R5 oe", {31'b0, oe}, 32'h0);
        dma_busy = 1'b0;
        cpu_read(2'd2, v); check("R5 status", {16'b0, v}, 32'h2);
        check("R5 irq", {30'b0, irq_out, irq_in}, 32'h0);
        cpu_read(2'd0, v); check("R5 inbox", {16'b0, v}, 32'h0F0F);

        // R9 clearing leaves data intact
        host_read(1'b1, v, oe);
        check("R3 oe", {31'b0, oe}, 32'h1);
        check("R7 irq_out", {31'b0, irq_out}, 32'h1);
        cpu_write(2'd2, 16'h0008);
        check("R9 irq_out", {31'b0, irq_out}, 32'h0);
        cpu_read(2'd1, v); check("R9 outbox", {16'b0, v}, 32'h5151);

        // R11 held strobe acts only on release, once
        @(negedge clk);
        hb_sel = 1'b1; hb_data_in = 16'h3C3C; hb_wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R11 held irq", {31'b0, irq_in}, 32'h0);
        cpu_read(2'd2, v); check("R11 held", {16'b0, v}, 32'h0);
        hb_wr_n = 1'b1;
        repeat (5) @(negedge clk);
        cpu_read(2'd2, v); check("R11 once", {16'b0, v}, 32'h5);
        cpu_read(2'd0, v); check("R11 data", {16'b0, v}, 32'h3C3C);
        cpu_write(2'd2, 16'h0004);

        // R10 set beats clear on inbound-full and on inbound pending
        host_write(1'b1, 16'h1111);
        host_write_collide(16'h2222, 1'b0, v);
        check("R10 old word", {16'b0, v}, 32'h1111);
        cpu_read(2'd2, v); check("R10 full", {16'b0, v}, 32'h5);
        cpu_read(2'd0, v); check("R10 new word", {16'b0, v}, 32'h2222);
        host_write_collide(16'h3333, 1'b1, v);
        check("R10 irq_in", {31'b0, irq_in}, 32'h1);
        cpu_read(2'd2, v); check("R10 pend", {16'b0, v}, 32'h5);

        finish_run();
    end
endmodule